// File: doc/BRIEF.md
# MicroWire serial master

This block is a half-duplex synchronous serial master for MicroWire and SPI-style peripherals. A host reaches it through a small 16-bit register interface. To run a frame, software writes the outgoing word into the data register. It then writes the command register with a chip-select index and two bit counts. The frame first shifts up to 16 bits out on `sdo`, then shifts up to 16 bits in from `sdi`. The received word becomes readable at the same data offset.

Each of the four chip selects carries its own 6-bit setting:
- the edge on which input is sampled,
- the edge on which output is launched,
- the active level of the select line,
- a post-divider for the serial clock,
- an optional ready handshake.

A shared first-stage prescaler outside this block supplies the `tick` enable. The post-divider counts these ticks. One global bit sets the idle level of `sclk`. A select stays asserted across frames until a command explicitly releases it.

Top module: `uw_master`

## Requirements
- R1: Register offsets are: 0 data (a write loads the transmit word, a read returns the receive word), 1 command/status, 2 settings of selects 0 and 1, 3 settings of selects 2 and 3, 4 clock idle control (bit 0). In offsets 2 and 3 the even select uses bits 5:0 and the odd select uses bits 11:6. Offsets 2, 3 and 4 read back what was written, with unused bits zero.
- R2: Command/status fields are: bit 15 read-data-ready, bit 14 busy (both read-only), bit 13 start, bit 12 select command, bits 11:10 select index, bits 9:5 write count, bits 4:0 read count. Bits 12:0 read back the last accepted command. A count above 16 acts as 16.
- R3: A frame shifts out exactly the write-count bits, starting from bit 15 of the transmit word. `sclk` makes one full cycle per bit, for write count plus read count cycles in total.
- R4: The read bits follow the write bits. The last bit received lands in bit 0 of the receive word, and the bits above the read count are zero.
- R5: Setting bit 0 set samples `sdi` on the falling edge of the un-inverted clock; clear samples on the rising edge. Setting bit 1 set launches `sdo` on the rising edge; clear launches it at frame start and on falling edges.
- R6: Setting bits 4:3 give an `sclk` half-period of 1, 2 or 4 ticks for codes 00, 01, 10. Code 11 behaves as 10.
- R7: When register 4 bit 0 is set, `sclk` idles high and every level is inverted. Whenever the block is not busy, `sclk` sits at its idle level.
- R8: A command with bit 12 set asserts only the indexed select and releases all others. A command with bit 12 clear releases the indexed select. Selects persist across frames. Setting bit 2 makes a select active high; otherwise it is active low.
- R9: Busy rises in the cycle after an accepted start and falls after the last clock edge. A command written while busy is ignored entirely.
- R10: Read-data-ready sets when a frame with a nonzero read count completes. It clears when the data register is read.
- R11: A start with both counts zero holds busy for exactly one cycle and produces no `sclk` edge.
- R12: With setting bit 5 set, the first `sclk` edge waits until `sdi` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable from the shared prescaler |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ready on data reads) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select lines at their configured polarity |

## Verification
The bench builds the block with its default parameters: 16-bit data, four selects and 5-bit count fields. This makes every select index, every divider code and full 16-bit frames reachable. It also reaches counts above 16, which exercise the clamp. Random frames mix all edge modes, clock inversion and a slowed prescaler tick. Directed cases cover:
- zero-length starts,
- commands written mid-frame,
- the ready hold-off,
- releasing selects.

// File: rtl/uw_pkg.sv
package uw_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_CS   = 4;
    localparam int CS_IDX_W = $clog2(NUM_CS);
    localparam int CNT_W    = 5;
    localparam int MODE_W   = 6;
    localparam int ADDR_W   = 3;
    localparam int HALF_W   = 3;
    localparam int BIT_W    = CNT_W + 1;
    localparam int CMD_W    = 1 + CS_IDX_W + 2 * CNT_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 3'd0,
        RA_CMD    = 3'd1,
        RA_PAIR_A = 3'd2,
        RA_PAIR_B = 3'd3,
        RA_CLKCFG = 3'd4
    } reg_addr_e;

    // per-select setting, bit 5 down to bit 0
    typedef struct packed {
        logic       chk_ready;
        logic [1:0] div_sel;
        logic       cs_high;
        logic       launch_rise;
        logic       sample_fall;
    } cs_mode_t;

    // what the shift engine latches at frame start
    typedef struct packed {
        logic       chk_ready;
        logic [1:0] div_sel;
        logic       launch_rise;
        logic       sample_fall;
    } eng_cfg_t;

    // command bits 12:0
    typedef struct packed {
        logic                cs_on;
        logic [CS_IDX_W-1:0] cs_idx;
        logic [CNT_W-1:0]    wr_bits;
        logic [CNT_W-1:0]    rd_bits;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LO,
        ST_HI,
        ST_DONE
    } eng_state_e;

    function automatic logic [CNT_W-1:0] clamp_bits(input logic [CNT_W-1:0] n);
        return (n > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : n;
    endfunction

    function automatic logic [HALF_W-1:0] half_ticks(input logic [1:0] sel);
        case (sel)
            2'b00:   return HALF_W'(1);
            2'b01:   return HALF_W'(2);
            default: return HALF_W'(4);
        endcase
    endfunction
endpackage

// File: rtl/uw_regs.sv
module uw_regs
    import uw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NC = NUM_CS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    input  logic                  busy,
    input  logic                  rx_load,
    input  logic [DW-1:0]         rx_word,
    output logic [DW-1:0]         tx_word,
    output cmd_t                  cmd_now,
    output logic                  cmd_go,
    output logic                  start_go,
    output cs_mode_t [NC-1:0]     modes,
    output logic                  sclk_inv
);
    localparam int PAIR_W = 2 * MODE_W;
    localparam int NPAIR  = NC / 2;

    logic [NPAIR-1:0][PAIR_W-1:0] pair_q;
    logic [DW-1:0]                rx_q;
    logic [CMD_W-1:0]             cmd_q;
    logic                         rdy_q;
    logic                         inv_q;

    assign cmd_now  = cmd_t'(wdata[CMD_W-1:0]);
    assign cmd_go   = wr && (addr == RA_CMD) && !busy;
    assign start_go = cmd_go && wdata[CMD_W];
    assign sclk_inv = inv_q;

    for (genvar i = 0; i < NC; i++) begin : g_mode
        assign modes[i] = cs_mode_t'(pair_q[i/2][(i%2)*MODE_W +: MODE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q  <= '0;
            tx_word <= '0;
            rx_q    <= '0;
            cmd_q   <= '0;
            rdy_q   <= 1'b0;
            inv_q   <= 1'b0;
        end else begin
            if (wr) begin
                case (addr)
                    RA_DATA:   tx_word   <= wdata;
                    RA_PAIR_A: pair_q[0] <= wdata[PAIR_W-1:0];
                    RA_PAIR_B: pair_q[1] <= wdata[PAIR_W-1:0];
                    RA_CLKCFG: inv_q     <= wdata[0];
                    default: ;
                endcase
            end
            if (cmd_go) cmd_q <= wdata[CMD_W-1:0];
            if (rx_load) begin
                rx_q  <= rx_word;
                rdy_q <= 1'b1;
            end else if (rd && (addr == RA_DATA)) begin
                rdy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            RA_DATA:   rdata = rx_q;
            RA_CMD:    rdata = {rdy_q, busy, 1'b0, cmd_q};
            RA_PAIR_A: rdata = DW'(pair_q[0]);
            RA_PAIR_B: rdata = DW'(pair_q[1]);
            RA_CLKCFG: rdata = DW'(inv_q);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/uw_shift.sv
module uw_shift
    import uw_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] wr_bits,
    input  logic [CNT_W-1:0] rd_bits,
    input  logic [DW-1:0]    tx_word,
    input  eng_cfg_t         cfg,
    input  logic             sdi,
    output logic             busy,
    output logic             sclk_raw,
    output logic             sdo,
    output logic [DW-1:0]    rx_word,
    output logic             rx_load
);
    eng_state_e        state;
    eng_cfg_t          cfg_q;
    logic [DW-1:0]     sh;
    logic [DW-1:0]     rx;
    logic [BIT_W-1:0]  nw;
    logic [BIT_W-1:0]  ntot;
    logic [BIT_W-1:0]  bitn;
    logic [HALF_W-1:0] tcnt;
    logic              rd_any;

    logic [CNT_W-1:0]  wr_c;
    logic [CNT_W-1:0]  rd_c;
    logic [HALF_W-1:0] last_cnt;
    logic [BIT_W-1:0]  bitn_nx;
    logic              writing;
    logic              reading;
    logic              next_writing;

    assign wr_c         = clamp_bits(wr_bits);
    assign rd_c         = clamp_bits(rd_bits);
    assign last_cnt     = half_ticks(cfg_q.div_sel) - HALF_W'(1);
    assign bitn_nx      = bitn + BIT_W'(1);
    assign writing      = bitn < nw;
    assign reading      = !writing;
    assign next_writing = bitn_nx < nw;

    assign busy     = (state != ST_IDLE);
    assign rx_word  = rx;
    assign rx_load  = (state == ST_DONE) && rd_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            sh       <= '0;
            rx       <= '0;
            nw       <= '0;
            ntot     <= '0;
            bitn     <= '0;
            tcnt     <= '0;
            rd_any   <= 1'b0;
            sclk_raw <= 1'b0;
            sdo      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q    <= cfg;
                        rx       <= '0;
                        nw       <= BIT_W'(wr_c);
                        ntot     <= BIT_W'(wr_c) + BIT_W'(rd_c);
                        rd_any   <= (rd_c != '0);
                        bitn     <= '0;
                        tcnt     <= '0;
                        sclk_raw <= 1'b0;
                        if ((wr_c != '0) && !cfg.launch_rise) begin
                            sdo <= tx_word[DW-1];
                            sh  <= tx_word << 1;
                        end else begin
                            sdo <= 1'b0;
                            sh  <= tx_word;
                        end
                        if ((wr_c == '0) && (rd_c == '0)) state <= ST_DONE;
                        else if (cfg.chk_ready)             state <= ST_WAIT;
                        else                                state <= ST_LO;
                    end
                end
                ST_WAIT: begin
                    if (sdi) state <= ST_LO;
                end
                ST_LO: begin
                    if (tick) begin
                        if (tcnt == last_cnt) begin
                            tcnt     <= '0;
                            sclk_raw <= 1'b1;
                            state    <= ST_HI;
                            if (!cfg_q.sample_fall && reading) rx <= {rx[DW-2:0], sdi};
                            if (cfg_q.launch_rise && writing) begin
                                sdo <= sh[DW-1];
                                sh  <= sh << 1;
                            end
                        end else begin
                            tcnt <= tcnt + HALF_W'(1);
                        end
                    end
                end
                ST_HI: begin
                    if (tick) begin
                        if (tcnt == last_cnt) begin
                            tcnt     <= '0;
                            sclk_raw <= 1'b0;
                            bitn     <= bitn_nx;
                            if (cfg_q.sample_fall && reading) rx <= {rx[DW-2:0], sdi};
                            if (!cfg_q.launch_rise && next_writing) begin
                                sdo <= sh[DW-1];
                                sh  <= sh << 1;
                            end
                            state <= (bitn_nx == ntot) ? ST_DONE : ST_LO;
                        end else begin
                            tcnt <= tcnt + HALF_W'(1);
                        end
                    end
                end
                ST_DONE: begin
                    sdo   <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uw_csel.sv
module uw_csel
    import uw_pkg::*;
#(
    parameter int NC = NUM_CS,
    parameter int IW = CS_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_go,
    input  logic          cs_on,
    input  logic [IW-1:0] cs_idx,
    input  logic [NC-1:0] cs_high,
    output logic [NC-1:0] active,
    output logic [NC-1:0] cs_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (cmd_go) begin
            if (cs_on) active <= NC'(1) << cs_idx;
            else       active[cs_idx] <= 1'b0;
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_pin
        assign cs_out[i] = active[i] ? cs_high[i] : ~cs_high[i];
    end
endmodule

// File: rtl/uw_master.sv
module uw_master
    import uw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic [NUM_CS-1:0] cs_out
);
    logic                      busy;
    logic                      rx_load;
    logic [DATA_W-1:0]         rx_word;
    logic [DATA_W-1:0]         tx_word;
    cmd_t                      cmd_now;
    logic                      cmd_go;
    logic                      start_go;
    cs_mode_t [NUM_CS-1:0]     modes;
    logic                      sclk_inv;
    logic                      sclk_raw;
    logic [NUM_CS-1:0]         cs_high;
    logic [NUM_CS-1:0]         active;
    cs_mode_t                  sel_mode;
    eng_cfg_t                  eng_cfg;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_pol
        assign cs_high[i] = modes[i].cs_high;
    end

    assign sel_mode = modes[cmd_now.cs_idx];
    assign eng_cfg  = '{chk_ready:   sel_mode.chk_ready,
                        div_sel:     sel_mode.div_sel,
                        launch_rise: sel_mode.launch_rise,
                        sample_fall: sel_mode.sample_fall};
    assign sclk     = sclk_raw ^ sclk_inv;

    uw_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .rx_load  (rx_load),
        .rx_word  (rx_word),
        .tx_word  (tx_word),
        .cmd_now  (cmd_now),
        .cmd_go   (cmd_go),
        .start_go (start_go),
        .modes    (modes),
        .sclk_inv (sclk_inv)
    );

    uw_shift i_shift (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start    (start_go),
        .wr_bits  (cmd_now.wr_bits),
        .rd_bits  (cmd_now.rd_bits),
        .tx_word  (tx_word),
        .cfg      (eng_cfg),
        .sdi      (sdi),
        .busy     (busy),
        .sclk_raw (sclk_raw),
        .sdo      (sdo),
        .rx_word  (rx_word),
        .rx_load  (rx_load)
    );

    uw_csel i_csel (
        .clk     (clk),
        .rst     (rst),
        .cmd_go  (cmd_go),
        .cs_on   (cmd_now.cs_on),
        .cs_idx  (cmd_now.cs_idx),
        .cs_high (cs_high),
        .active  (active),
        .cs_out  (cs_out)
    );
endmodule

// File: rtl/uw_master_chk.sv
module uw_master_chk
    import uw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sclk,
    input logic              sclk_inv,
    input logic              busy,
    input logic              start_go,
    input logic              cmd_go,
    input logic              rx_load,
    input logic [NUM_CS-1:0] active
);
    logic zero_len;
    logic data_rd;
    logic cmd_wr;
    assign zero_len = (reg_wdata[2*CNT_W-1:CNT_W] == '0) && (reg_wdata[CNT_W-1:0] == '0);
    assign data_rd  = reg_rd && (reg_addr == RA_DATA);
    assign cmd_wr   = reg_wr && (reg_addr == RA_CMD);

    // R8: at most one select asserted
    a_r8_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));

    // R8: selects only move on an accepted command
    a_r8_select_held: assert property (@(posedge clk) disable iff (rst)
        !cmd_go |=> $stable(active));

    // R9: accepted start raises busy next cycle
    a_r9_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && reg_wdata[13] && !busy) |=> busy);

    // R9: command while busy leaves selects alone
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(active));

    // R7: serial clock at idle level whenever not busy
    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == sclk_inv));

    // R10: ready sets after a read frame
    a_r10_ready_set: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> (reg_addr != RA_CMD) || reg_rdata[15]);

    // R10: ready clears after reading data
    a_r10_ready_clear: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_load) |=> (reg_addr != RA_CMD) || !reg_rdata[15]);

    // R11: zero-length start is busy for exactly one cycle
    a_r11_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start_go && zero_len) |=> busy ##1 !busy);
endmodule

bind uw_master uw_master_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sclk      (sclk),
    .sclk_inv  (sclk_inv),
    .busy      (busy),
    .start_go  (start_go),
    .cmd_go    (cmd_go),
    .rx_load   (rx_load),
    .active    (active)
);

// File: tb/test_uw_master.sv
`timescale 1ns/1ps
module test_uw_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        sclk;
    logic        sdo;
    logic        sdi = 1'b1;
    logic [3:0]  cs_out;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          slow = 0;
    int          tdiv = 0;
    logic [5:0]  mode_m [4];
    logic        inv_m = 1'b0;
    logic [3:0]  active_m = 4'h0;

    always #2 clk = ~clk;

    uw_master i_uw_master (
        .clk(clk), .rst(rst), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_out(cs_out)
    );

    always @(negedge clk) begin
        if (slow) begin
            tdiv = (tdiv == 2) ? 0 : tdiv + 1;
            tick <= (tdiv == 0);
        end else begin
            tick <= 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clampn(input int n);
        return (n > 16) ? 16 : n;
    endfunction

    function automatic int exp_half(input logic [1:0] d);
        return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [15:0] exp_tx(input logic [15:0] tx, input int n);
        return (n == 0) ? 16'h0 : 16'(tx >> (16 - n));
    endfunction

    function automatic logic [15:0] exp_rx(input logic [15:0] p, input int n);
        return (n == 16) ? p : (p & 16'((1 << n) - 1));
    endfunction

    function automatic logic [3:0] exp_cs();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = active_m[i] ? mode_m[i][2] : ~mode_m[i][2];
        return v;
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(input int cs, input logic [5:0] m);
        int p;
        mode_m[cs] = m;
        p = cs / 2;
        reg_write(3'(2 + p), {4'h0, mode_m[2*p+1], mode_m[2*p]});
    endtask

    task automatic set_inv(input logic v);
        inv_m = v;
        reg_write(3'd4, {15'h0, v});
    endtask

    task automatic run_frame(input int cs, input int wr_f, input int rd_f,
                             input logic [15:0] tx, input logic [15:0] rxp,
                             input int hold, input bit intrude);
        int wr_e, rd_e, tot, rises, falls, cyc, r1c, f1c, k, j;
        logic prev, cur;
        logic [15:0] cap, v, cmd;
        wr_e = clampn(wr_f);
        rd_e = clampn(rd_f);
        tot = wr_e + rd_e;
        reg_write(3'd0, tx);
        if (hold > 0) sdi = 1'b0;
        else if (wr_e == 0 && rd_e > 0) sdi = rxp[rd_e-1];
        else sdi = 1'b1;
        cmd = 16'h3000 | 16'(cs << 10) | 16'((wr_f & 31) << 5) | 16'(rd_f & 31);
        reg_write(3'd1, cmd);
        active_m = 4'(1 << cs);
        rises = 0; falls = 0; cyc = 0; cap = 0; r1c = 0; f1c = 0;
        prev = 1'b0;
        forever begin
            cur = sclk ^ inv_m;
            if (cur && !prev) begin
                rises++;
                if (rises == 1) r1c = cyc;
                if (!mode_m[cs][1] && rises <= wr_e) cap = {cap[14:0], sdo};
            end
            if (!cur && prev) begin
                falls++;
                if (falls == 1) f1c = cyc;
                if (mode_m[cs][1] && falls <= wr_e) cap = {cap[14:0], sdo};
            end
            prev = cur;
            if (hold > 0 && cyc == hold)
                check(rises + falls == 0 && i_uw_master.sclk == inv_m, "R12 no edge before ready",
                      rises + falls, 0);
            if (cyc < hold) sdi = 1'b0;
            else begin
                k = falls; j = k - wr_e;
                sdi = (j >= 0 && j < rd_e) ? rxp[rd_e-1-j] : 1'b1;
            end
            if (intrude && cyc == 3) begin
                reg_addr = 3'd1; reg_wdata = 16'h3000 | 16'(((cs ^ 1) & 3) << 10) | 16'h0021; reg_wr = 1'b1;
            end
            if (intrude && cyc == 4) reg_wr = 1'b0;
            if (cyc > 2000) break;
            reg_read_busy(v);
            if (!v[14] && cyc > 0) break;
            @(negedge clk);
            cyc++;
        end
        check(rises == tot && falls == tot, "R3 sclk cycles", rises, tot);
        check(cap == exp_tx(tx, wr_e), "R3/R5 sdo bits", cap, exp_tx(tx, wr_e));
        if (!slow && tot > 0)
            check(f1c - r1c == exp_half(mode_m[cs][4:3]), "R6 half period",
                  f1c - r1c, exp_half(mode_m[cs][4:3]));
        check(cs_out == exp_cs(), "R8 select lines", cs_out, exp_cs());
        reg_read(3'd1, v);
        check(v[15] == (rd_e > 0), "R10 ready after frame", v[15], rd_e > 0);
        check(v[12:0] == cmd[12:0] && v[14:13] == 2'b00, "R2 status readback", v, cmd[12:0]);
        if (rd_e > 0) begin
            reg_read(3'd0, v);
            check(v == exp_rx(rxp, rd_e), "R4/R5 receive word", v, exp_rx(rxp, rd_e));
            reg_read(3'd1, v);
            check(!v[15], "R10 ready cleared", v[15], 0);
        end
    endtask

    // peek busy through the status register without a read strobe
    task automatic reg_read_busy(output logic [15:0] v);
        logic [2:0] sa;
        logic       sw;
        sa = reg_addr; sw = reg_wr;
        if (!sw) reg_addr = 3'd1;
        #1 v = sw ? 16'h4000 : reg_rdata;
        if (!sw) reg_addr = sa;
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 4; i++) mode_m[i] = 6'h0;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(cs_out == 4'hF, "R8 reset selects inactive", cs_out, 4'hF);
        check(sclk == 1'b0 && sdo == 1'b0, "R7 reset idle", {sclk, sdo}, 0);
        reg_read(3'd1, v);
        check(v == 16'h0, "R2 reset status", v, 0);

        // register readback
        reg_write(3'd2, 16'hFABC);
        reg_read(3'd2, v);
        check(v == 16'h0ABC, "R1 pair A readback", v, 16'h0ABC);
        reg_write(3'd3, 16'h1555);
        reg_read(3'd3, v);
        check(v == 16'h0555, "R1 pair B readback", v, 16'h0555);
        reg_write(3'd2, 16'h0); reg_write(3'd3, 16'h0);
        set_inv(1'b1);
        reg_read(3'd4, v);
        check(v == 16'h1, "R1 clock control readback", v, 1);
        check(sclk == 1'b1, "R7 inverted idle", sclk, 1);
        set_inv(1'b0);

        // directed frames
        set_mode(0, 6'b000000);
        run_frame(0, 8, 0, 16'hA5C3, 16'h0, 0, 0);
        set_mode(1, 6'b001011);
        run_frame(1, 0, 12, 16'h0, 16'h0B6D, 0, 0);
        set_mode(2, 6'b010101);
        set_inv(1'b1);
        run_frame(2, 16, 16, 16'h8001, 16'hC3A5, 0, 0);
        set_inv(1'b0);
        set_mode(3, 6'b011110);
        run_frame(3, 20, 1, 16'h7F0E, 16'h0001, 0, 0);   // R2 clamp
        run_frame(0, 0, 0, 16'hFFFF, 16'h0, 0, 0);        // R11 zero-length
        set_mode(1, 6'b010000);
        run_frame(1, 16, 4, 16'h1234, 16'h000A, 0, 1);    // R9 intruding command
        set_mode(2, 6'b100000);
        run_frame(2, 5, 3, 16'hD800, 16'h0005, 6, 0);     // R12 ready hold-off

        // R8 explicit select control
        reg_write(3'd1, 16'h0000 | 16'(2 << 10));
        active_m[2] = 1'b0;
        @(negedge clk);
        check(cs_out == exp_cs(), "R8 release indexed select", cs_out, exp_cs());
        set_mode(3, 6'b000100);
        reg_write(3'd1, 16'h1000 | 16'(3 << 10));
        active_m = 4'b1000;
        @(negedge clk);
        check(cs_out == exp_cs(), "R8 assert active-high select", cs_out, exp_cs());
        reg_write(3'd1, 16'h0000 | 16'(1 << 10));
        @(negedge clk);
        check(cs_out == exp_cs(), "R8 release of idle select no effect", cs_out, exp_cs());

        // random frames
        for (int n = 0; n < 40; n++) begin
            int cs, wr_f, rd_f;
            cs = $urandom_range(0, 3);
            set_mode(cs, 6'($urandom_range(0, 31)));
            set_inv(1'($urandom_range(0, 1)));
            slow = ($urandom_range(0, 3) == 0);
            wr_f = $urandom_range(0, 18);
            rd_f = $urandom_range(0, 18);
            run_frame(cs, wr_f, rd_f, 16'($urandom), 16'($urandom), 0, 0);
        end
        slow = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule